// File: doc/BRIEF.md
# I2C Master Register Front End

This block sits between a simple synchronous microprocessor bus and an I2C master engine. The processor drives a 3-bit register offset, 8-bit write data, and chip select, read and write qualifiers. All of these are sampled on the system clock. The block holds the slave address, control, status and data registers. It returns read data for the selected offset.

A write is committed on the third rising clock edge at which chip select is seen high. It is committed only once per chip-select assertion. The processor side must therefore hold the offset and the data stable for the whole time chip select is high. When the control or data register is written, the block gives the engine a single-cycle strobe. The engine reports its events back to the block: arbitration loss, completion of a repeated start, interrupt requests and received bytes. Some of these events clear control bits without any processor action. Separate request inputs clear the sticky interrupt-pending and arbitration-lost flags.

Top module: `i2c_host_regs`

## Requirements
- R1: On a synchronous active-high reset, all registers and outputs are zero: slave address, control, data, both sticky flags, both strobes and `irq`.
- R2: A write is committed on the third rising edge at which `cs` is sampled high, when `wr` is high at that edge. If `cs` drops before that edge, nothing is written. If `cs` stays high longer, the write is still committed only once.
- R3: When `cs` and `rd` are both high, `rdata` returns the register selected by `addr`. Offset 0 is the slave address, 1 is control, 2 is status and 3 is data. Offsets 4 to 7 read zero. `rdata` is zero whenever `cs` and `rd` are not both high. Status layout: bit 0 interrupt pending, bit 1 arbitration lost, bit 2 `eng_busy` (live), bit 3 `eng_done` (live), bits 7:4 zero.
- R4: `ctrl_wr_stb` is high for exactly one cycle, the cycle after a commit to offset 1. `data_wr_stb` behaves the same way for offset 3.
- R5: A write to offset 2 or to offsets 4 to 7 changes no register.
- R6: An `eng_arb_lost` pulse clears control bit 5 (master mode). It also sets the arbitration-lost and interrupt-pending status bits. The clear wins over a control write in the same cycle.
- R7: An `eng_rsta_done` pulse clears control bit 2 (repeated start). The clear wins over a control write in the same cycle.
- R8: `clr_irq` clears interrupt pending and `clr_arb` clears arbitration lost. A set event in the same cycle wins over the clear. Interrupt pending is set by `eng_irq_set` or by `eng_arb_lost`.
- R9: `irq` is high exactly when interrupt pending is set and control bit 6 (interrupt enable) is set.
- R10: `eng_rx_valid` loads `eng_rx_data` into the data register. It wins over a processor data write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select from the processor |
| rd | input | 1 | Read qualifier |
| wr | input | 1 | Write qualifier |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| eng_busy | input | 1 | Bus busy level from the engine |
| eng_done | input | 1 | Transfer complete level from the engine |
| eng_irq_set | input | 1 | Interrupt request pulse from the engine |
| eng_arb_lost | input | 1 | Arbitration lost pulse |
| eng_rsta_done | input | 1 | Repeated start issued pulse |
| eng_rx_valid | input | 1 | Received byte valid pulse |
| eng_rx_data | input | 8 | Received byte |
| clr_irq | input | 1 | Clear request for interrupt pending |
| clr_arb | input | 1 | Clear request for arbitration lost |
| slave_addr | output | 8 | Slave address register |
| ctrl | output | 8 | Control register |
| data_out | output | 8 | Data register |
| ctrl_wr_stb | output | 1 | Control register written strobe |
| data_wr_stb | output | 1 | Data register written strobe |
| irq | output | 1 | Interrupt pending output |

## Verification
The assertions check the following on every cycle:
- Each strobe is single-cycle and is preceded by three cycles with chip select high.
- The engine's arbitration-loss and repeated-start events clear their control bits on the next cycle.
- The interrupt output requires the enable bit.
- Upper offsets and idle cycles return zero read data.

Some behaviour shows only in the bench's scenarios, where a reference model is compared against the outputs every clock:
- A short chip-select pulse writes nothing.
- A long chip-select pulse writes exactly once.
- Writes to the status and unused offsets are ignored.
- Set-versus-clear priority on the sticky flags.
- The received byte overrides a processor write.

// File: rtl/i2c_host_regs.sv
module i2c_host_regs #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          eng_busy,
  input  logic          eng_done,
  input  logic          eng_irq_set,
  input  logic          eng_arb_lost,
  input  logic          eng_rsta_done,
  input  logic          eng_rx_valid,
  input  logic [DW-1:0] eng_rx_data,
  input  logic          clr_irq,
  input  logic          clr_arb,
  output logic [DW-1:0] slave_addr,
  output logic [DW-1:0] ctrl,
  output logic [DW-1:0] data_out,
  output logic          ctrl_wr_stb,
  output logic          data_wr_stb,
  output logic          irq
);
  localparam logic [AW-1:0] OFS_SADR = AW'(0);
  localparam logic [AW-1:0] OFS_CTRL = AW'(1);
  localparam logic [AW-1:0] OFS_STAT = AW'(2);
  localparam logic [AW-1:0] OFS_DATA = AW'(3);
  localparam int BIT_RSTA = 2;
  localparam int BIT_MSTR = 5;
  localparam int BIT_IEN  = 6;
  localparam logic [1:0] COMMIT_AT = 2'd2;

  logic [1:0]    cs_cnt;
  logic          commit;
  logic [DW-1:0] sadr_q, ctrl_q, ctrl_d, data_q;
  logic          irq_q, arb_q, cstb_q, dstb_q;
  logic [DW-1:0] stat;

  assign commit = cs && wr && (cs_cnt == COMMIT_AT);
  assign stat   = {{(DW-4){1'b0}}, eng_done, eng_busy, arb_q, irq_q};

  always_comb begin
    ctrl_d = ctrl_q;
    if (commit && addr == OFS_CTRL) ctrl_d = wdata;
    if (eng_arb_lost)  ctrl_d[BIT_MSTR] = 1'b0;
    if (eng_rsta_done) ctrl_d[BIT_RSTA] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_cnt <= '0;
      sadr_q <= '0;
      ctrl_q <= '0;
      data_q <= '0;
      irq_q  <= 1'b0;
      arb_q  <= 1'b0;
      cstb_q <= 1'b0;
      dstb_q <= 1'b0;
    end else begin
      if (!cs) cs_cnt <= '0;
      else if (cs_cnt != 2'd3) cs_cnt <= cs_cnt + 2'd1;
      cstb_q <= commit && addr == OFS_CTRL;
      dstb_q <= commit && addr == OFS_DATA;
      if (commit && addr == OFS_SADR) sadr_q <= wdata;
      ctrl_q <= ctrl_d;
      if (eng_rx_valid) data_q <= eng_rx_data;
      else if (commit && addr == OFS_DATA) data_q <= wdata;
      if (eng_irq_set || eng_arb_lost) irq_q <= 1'b1;
      else if (clr_irq) irq_q <= 1'b0;
      if (eng_arb_lost) arb_q <= 1'b1;
      else if (clr_arb) arb_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (cs && rd) begin
      unique case (addr)
        OFS_SADR: rdata = sadr_q;
        OFS_CTRL: rdata = ctrl_q;
        OFS_STAT: rdata = stat;
        OFS_DATA: rdata = data_q;
        default:  rdata = '0;
      endcase
    end
  end

  assign slave_addr  = sadr_q;
  assign ctrl        = ctrl_q;
  assign data_out    = data_q;
  assign ctrl_wr_stb = cstb_q;
  assign data_wr_stb = dstb_q;
  assign irq         = irq_q & ctrl_q[BIT_IEN];
endmodule

// File: rtl/i2c_host_regs_chk.sv
module i2c_host_regs_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs,
  input logic       rd,
  input logic [2:0] addr,
  input logic [7:0] rdata,
  input logic [7:0] ctrl,
  input logic       ctrl_wr_stb,
  input logic       data_wr_stb,
  input logic       irq,
  input logic       eng_arb_lost,
  input logic       eng_rsta_done,
  input logic       eng_irq_set,
  input logic       clr_irq,
  input logic       irq_q,
  input logic       arb_q
);
  // R4
  ctrl_stb_single_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr_stb |=> !ctrl_wr_stb);
  // R4
  data_stb_single_chk: assert property (@(posedge clk) disable iff (rst)
    data_wr_stb |=> !data_wr_stb);
  // R2
  stb_after_three_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr_stb || data_wr_stb) |-> ($past(cs) && $past(cs, 2) && $past(cs, 3)));
  // R6
  arb_clears_mstr_chk: assert property (@(posedge clk) disable iff (rst)
    eng_arb_lost |=> (!ctrl[5] && arb_q && irq_q));
  // R7
  rsta_self_clear_chk: assert property (@(posedge clk) disable iff (rst)
    eng_rsta_done |=> !ctrl[2]);
  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_irq && !eng_irq_set && !eng_arb_lost) |=> !irq_q);
  // R9
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ctrl[6]);
  // R3
  upper_ofs_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!(cs && rd) || addr[2]) |-> rdata == 8'h00);
endmodule

bind i2c_host_regs i2c_host_regs_chk u_chk (
  .clk(clk), .rst(rst), .cs(cs), .rd(rd), .addr(addr), .rdata(rdata),
  .ctrl(ctrl), .ctrl_wr_stb(ctrl_wr_stb), .data_wr_stb(data_wr_stb),
  .irq(irq), .eng_arb_lost(eng_arb_lost), .eng_rsta_done(eng_rsta_done),
  .eng_irq_set(eng_irq_set), .clr_irq(clr_irq), .irq_q(irq_q), .arb_q(arb_q)
);

// File: tb/i2c_host_regs_tb.sv
`timescale 1ns/1ps
module i2c_host_regs_tb;
  logic clk = 0, rst = 1;
  logic cs = 0, rd = 0, wr = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, eng_rx_data = 0;
  logic eng_busy = 0, eng_done = 0, eng_irq_set = 0, eng_arb_lost = 0;
  logic eng_rsta_done = 0, eng_rx_valid = 0, clr_irq = 0, clr_arb = 0;
  logic [7:0] rdata, slave_addr, ctrl, data_out;
  logic ctrl_wr_stb, data_wr_stb, irq;

  always #4 clk = ~clk;

  i2c_host_regs u_dut (.*);

  int checks = 0, fails = 0, cyc = 0;
  int m_cnt, m_sadr, m_ctrl, m_data, m_irq, m_arb, m_cstb, m_dstb;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_rdata();
    if (!(cs && rd)) return 0;
    case (addr)
      3'd0: return m_sadr;
      3'd1: return m_ctrl;
      3'd2: return (int'(eng_done) << 3) | (int'(eng_busy) << 2) | (m_arb << 1) | m_irq;
      3'd3: return m_data;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int commit;
    int nc;
    cyc++;
    if (rst) begin
      m_cnt = 0; m_sadr = 0; m_ctrl = 0; m_data = 0;
      m_irq = 0; m_arb = 0; m_cstb = 0; m_dstb = 0;
    end else begin
      commit = (cs && wr && m_cnt == 2) ? 1 : 0;
      m_cnt  = cs ? (m_cnt < 3 ? m_cnt + 1 : 3) : 0;
      m_cstb = (commit && addr == 1) ? 1 : 0;
      m_dstb = (commit && addr == 3) ? 1 : 0;
      if (commit && addr == 0) m_sadr = wdata;
      nc = (commit && addr == 1) ? int'(wdata) : m_ctrl;
      if (eng_arb_lost) nc = nc & ~32'h20;
      if (eng_rsta_done) nc = nc & ~32'h04;
      m_ctrl = nc;
      if (eng_rx_valid) m_data = eng_rx_data;
      else if (commit && addr == 3) m_data = wdata;
      if (eng_irq_set || eng_arb_lost) m_irq = 1; else if (clr_irq) m_irq = 0;
      if (eng_arb_lost) m_arb = 1; else if (clr_arb) m_arb = 0;
    end
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
      $finish;
    end
  end

  always @(negedge clk) if (!rst) begin
    chk("R2 slave_addr", slave_addr, m_sadr);
    chk("R6 ctrl", ctrl, m_ctrl);
    chk("R10 data_out", data_out, m_data);
    chk("R4 ctrl_wr_stb", ctrl_wr_stb, m_cstb);
    chk("R4 data_wr_stb", data_wr_stb, m_dstb);
    chk("R9 irq", irq, m_irq & ((m_ctrl >> 6) & 1));
    chk("R3 rdata", rdata, exp_rdata());
  end

  task automatic cpu_write(input logic [2:0] a, input logic [7:0] d, input int n);
    @(posedge clk); #1 cs = 1; wr = 1; addr = a; wdata = d;
    repeat (n) @(posedge clk);
    #1 cs = 0; wr = 0;
    @(posedge clk);
  endtask

  task automatic cpu_read(input logic [2:0] a, output logic [7:0] v);
    @(posedge clk); #1 cs = 1; rd = 1; addr = a;
    @(negedge clk); v = rdata;
    @(posedge clk); #1 cs = 0; rd = 0;
  endtask

  task automatic settle();
    @(posedge clk); #1;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1
    chk("R1 slave_addr", slave_addr, 0); chk("R1 ctrl", ctrl, 0);
    chk("R1 data_out", data_out, 0);     chk("R1 irq", irq, 0);
    chk("R1 strobes", {ctrl_wr_stb, data_wr_stb}, 0);
    cpu_write(0, 8'hA5, 3); settle(); chk("R2 three-edge commit", slave_addr, 8'hA5);
    cpu_write(0, 8'h3C, 2); settle(); chk("R2 short cs ignored", slave_addr, 8'hA5);
    cpu_write(0, 8'h5A, 7); settle(); chk("R2 long cs single", slave_addr, 8'h5A);
    cpu_write(1, 8'hE4, 3); settle(); chk("R4 ctrl written", ctrl, 8'hE4);
    cpu_write(2, 8'hFF, 3); cpu_write(5, 8'hFF, 4);
    cpu_read(2, v); chk("R5 status write ignored", v, 8'h00);
    cpu_read(5, v); chk("R5 unused offset", v, 8'h00);
    cpu_read(0, v); chk("R5 sadr unchanged", v, 8'h5A);
    cpu_write(3, 8'h77, 4); cpu_read(3, v); chk("R4 data written", v, 8'h77);
    @(posedge clk); #1 eng_rsta_done = 1; @(posedge clk); #1 eng_rsta_done = 0;
    @(negedge clk); chk("R7 rsta cleared", ctrl, 8'hE0);
    @(posedge clk); #1 eng_arb_lost = 1; @(posedge clk); #1 eng_arb_lost = 0;
    @(negedge clk); chk("R6 mstr cleared", ctrl, 8'hC0); chk("R9 irq raised", irq, 1);
    cpu_read(2, v); chk("R6 status flags", v, 8'h03);
    @(posedge clk); #1 clr_arb = 1; @(posedge clk); #1 clr_arb = 0;
    cpu_read(2, v); chk("R8 arb cleared", v, 8'h01);
    @(posedge clk); #1 clr_irq = 1; eng_irq_set = 1;
    @(posedge clk); #1 clr_irq = 0; eng_irq_set = 0;
    cpu_read(2, v); chk("R8 set beats clear", v, 8'h01);
    cpu_write(1, 8'h80, 3); settle(); chk("R9 irq masked", irq, 0);
    @(posedge clk); #1 clr_irq = 1; @(posedge clk); #1 clr_irq = 0;
    cpu_read(2, v); chk("R8 irq cleared", v, 8'h00);
    @(posedge clk); #1 eng_rx_valid = 1; eng_rx_data = 8'h3E;
    @(posedge clk); #1 eng_rx_valid = 0;
    @(negedge clk); chk("R10 rx load", data_out, 8'h3E);
    // R10 rx byte wins over a same-cycle processor data write
    @(posedge clk); #1 cs = 1; wr = 1; addr = 3; wdata = 8'h11;
    @(posedge clk); @(posedge clk); eng_rx_valid = 1; eng_rx_data = 8'hC9;
    @(posedge clk); #1 eng_rx_valid = 0; cs = 0; wr = 0;
    @(negedge clk); chk("R10 rx priority", data_out, 8'hC9);
    #1 eng_busy = 1; eng_done = 1;
    cpu_read(2, v); chk("R3 live status bits", v, 8'h0C);
    cpu_read(7, v); chk("R3 offset 7 zero", v, 8'h00);
    settle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule